// File: doc/BRIEF.md
# CPU Core Reset and Cache Flush Control Register

This block is one 32-bit control and status register that owns the reset line of a single CPU core and the flush request of its L2 cache. Software writes the register through a plain write/read port. Every control bit in the lower half-word has a companion enable bit sixteen positions higher, so one write can change one bit and leave the others alone without a read-modify-write.

A parameter picks how the core reset behaves. In the self-releasing variant, one write starts a complete pulse and hardware removes the reset by itself. In the held variant, the reset stays on until software writes the bit back to 0. Each reset transition is wrapped in a clock-stop window: the core clock enable drops, the reset level changes, the block waits a programmable number of quarter-microsecond ticks, and then the clock comes back. In both variants, a sticky done flag reports that the reset has been removed. Software clears the flag by writing 1 to it.

The flush request is independent of the reset. Software sets it, the request output stays high, and the bit clears itself when the cache answers with a completion pulse.

Top module: `cpu_rst_ctl`

## Requirements
- R1: After reset, `rdData` reads 0, `coreRst` is 0, `coreClkEn` is 1 and `flushReq` is 0.
- R2: A write changes the reset bit (bit 0) or the flush bit (bit 4) only when the same write also sets the enable bit at that position plus 16 (bit 16 or bit 20). Without the enable bit, the target bit keeps its value and no action starts.
- R3: The done flag (bit 12) clears only on a write that sets both bit 12 and bit 28. When hardware sets the flag in the same cycle as such a write, the set wins.
- R4: Self-releasing variant: a write of 1 to bit 0 with its enable makes `rdData[0]` read 1 after that edge, and `coreRst` rises one cycle later. After the apply and removal phases, `coreRst` is 0, `rdData[0]` returns to 0 and the done flag becomes 1, all on the same edge.
- R5: Self-releasing variant: while `rdData[0]` reads 1, writes to bit 0 are ignored, so the pulse cannot be cut short.
- R6: Held variant: after the apply phase, `coreRst` stays 1 with `coreClkEn` 1 and the done flag at 0 until software writes 0 to bit 0. A removal phase then follows, at whose end the done flag sets.
- R7: Each phase keeps `coreClkEn` low until the edge after `cfgTicks` pulses of `tick` have been counted within that phase. A count of 0 gives a phase of exactly one cycle.
- R8: `coreRst` never changes level in a cycle in which `coreClkEn` is 1.
- R9: A write of 1 to bit 4 with enable bit 20 raises `flushReq`. The request stays high until a `flushDone` pulse clears it on the following edge. A `flushDone` pulse with no request pending has no effect, and the flush never touches the done flag.
- R10: `rdData` carries the reset bit at bit 0, the flush bit at bit 4 and the done flag at bit 12. All other bits, including every enable position, read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Register write strobe, one cycle per write |
| wrData | input | 32 | Write data: control values in bits 15:0, enables in bits 31:16 |
| rdData | output | 32 | Current register contents |
| tick | input | 1 | One-cycle pulse every quarter microsecond |
| cfgTicks | input | 4 | Length of each clock-stop phase in ticks, sampled when a phase starts |
| flushDone | input | 1 | Completion pulse from the L2 cache |
| coreRst | output | 1 | Core reset, active high |
| coreClkEn | output | 1 | Core clock enable, low during clock-stop phases |
| flushReq | output | 1 | L2 flush request, active high |

## Verification
Register bits are due one edge after their write, and `rdData` is due with them. `coreRst` and `coreClkEn` are due one edge after the state change that causes them. A phase ends on the edge after its tick count reaches zero. The bench drives the inputs on falling edges. For each rising edge, the driver pushes the full expected output set into a queue, and a monitor pops and compares it one nanosecond after that edge. Every expectation is therefore bound to one exact cycle. Ticks are issued only by the driver, so phase lengths in cycles are known exactly and the boundary cases (a zero count, a clear that collides with a set, a cancel write during a pulse) fall on known edges.

// File: rtl/cpu_rst_pkg.sv
package cpu_rst_pkg;

  // bit positions decoded by software; the enable of bit b sits at b + WE_OFS
  localparam int RST_POS   = 0;
  localparam int FLUSH_POS = 4;
  localparam int DONE_POS  = 12;
  localparam int WE_OFS    = 16;

  typedef enum logic [1:0] {
    SEQ_IDLE    = 2'd0,
    SEQ_APPLY   = 2'd1,
    SEQ_HOLD    = 2'd2,
    SEQ_RELEASE = 2'd3
  } seqState_t;

  // strobes from the sequencer into the register datapath
  typedef struct packed {
    logic setDone;  // removal phase finished
    logic clrRst;   // hardware drops the reset bit (self-releasing variant)
    logic lockRst;  // software writes to the reset bit are ignored
  } seqStrobe_t;

endpackage

// File: rtl/cpu_rst_regs.sv
module cpu_rst_regs
  import cpu_rst_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  input  logic              flushDone,
  input  seqStrobe_t        strb,
  output logic              rstBit,
  output logic              flushBit,
  output logic [DATA_W-1:0] rdData
);

  localparam int HALF_W = DATA_W / 2;

  logic doneBit;
  logic rstWe, flushWe, doneClr;

  assign rstWe   = wrEn && wrData[RST_POS + WE_OFS];
  assign flushWe = wrEn && wrData[FLUSH_POS + WE_OFS];
  assign doneClr = wrEn && wrData[DONE_POS + WE_OFS] && wrData[DONE_POS];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rstBit <= 1'b0;
    end else if (strb.clrRst) begin
      rstBit <= 1'b0;
    end else if (rstWe && !strb.lockRst) begin
      rstBit <= wrData[RST_POS];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      flushBit <= 1'b0;
    end else if (flushWe) begin
      flushBit <= wrData[FLUSH_POS];
    end else if (flushDone) begin
      flushBit <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      doneBit <= 1'b0;
    end else if (strb.setDone) begin
      doneBit <= 1'b1;
    end else if (doneClr) begin
      doneBit <= 1'b0;
    end
  end

  always_comb begin
    rdData            = '0;
    rdData[RST_POS]   = rstBit;
    rdData[FLUSH_POS] = flushBit;
    rdData[DONE_POS]  = doneBit;
  end

  logic unusedWr;
  assign unusedWr = ^wrData[HALF_W-1:0];

  AST_FLUSH_KEEP: assert property (@(posedge clk) disable iff (!rstN)
    (!flushWe && !flushDone) |=> flushBit == $past(flushBit)) else $error("flush bit moved without enable"); // R2
  AST_FLUSH_SELF_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    (flushDone && !flushWe) |=> !flushBit) else $error("flush not cleared by completion"); // R9
  AST_DONE_W1C: assert property (@(posedge clk) disable iff (!rstN)
    (doneClr && !strb.setDone) |=> !doneBit) else $error("done flag not cleared"); // R3
  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (doneBit && !doneClr) |=> doneBit) else $error("done flag dropped alone"); // R3

endmodule

// File: rtl/cpu_rst_seq.sv
module cpu_rst_seq
  import cpu_rst_pkg::*;
#(
  parameter int CNT_W        = 4,
  parameter bit AUTO_RELEASE = 1'b1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             rstBit,
  input  logic             tick,
  input  logic [CNT_W-1:0] cfgTicks,
  output seqStrobe_t       strb,
  output logic             coreRst,
  output logic             coreClkEn
);

  localparam seqState_t AFTER_APPLY = AUTO_RELEASE ? SEQ_RELEASE : SEQ_HOLD;

  seqState_t state, stateNxt;
  logic [CNT_W-1:0] cnt;
  logic load, waiting, cntZero, finish;

  assign waiting = (state == SEQ_APPLY) || (state == SEQ_RELEASE);
  assign cntZero = (cnt == '0);

  always_comb begin
    stateNxt = state;
    load     = 1'b0;
    finish   = 1'b0;
    unique case (state)
      SEQ_IDLE: if (rstBit) begin
        stateNxt = SEQ_APPLY;
        load     = 1'b1;
      end
      SEQ_APPLY: if (cntZero) begin
        stateNxt = AFTER_APPLY;
        load     = 1'b1;
      end
      SEQ_HOLD: if (!rstBit) begin
        stateNxt = SEQ_RELEASE;
        load     = 1'b1;
      end
      SEQ_RELEASE: if (cntZero) begin
        stateNxt = SEQ_IDLE;
        finish   = 1'b1;
      end
      default: stateNxt = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= SEQ_IDLE;
      cnt   <= '0;
    end else begin
      state <= stateNxt;
      if (load) begin
        cnt <= cfgTicks;
      end else if (waiting && !cntZero && tick) begin
        cnt <= cnt - CNT_W'(1);
      end
    end
  end

  assign coreRst   = (state == SEQ_APPLY) || (state == SEQ_HOLD);
  assign coreClkEn = (state == SEQ_IDLE) || (state == SEQ_HOLD);

  assign strb.setDone = finish;

  generate
    if (AUTO_RELEASE) begin : g_auto
      assign strb.clrRst  = finish;
      assign strb.lockRst = rstBit;
      AST_NO_HOLD: assert property (@(posedge clk) disable iff (!rstN)
        state != SEQ_HOLD) else $error("held state in self-releasing variant"); // R4
    end else begin : g_held
      assign strb.clrRst  = 1'b0;
      assign strb.lockRst = 1'b0;
      AST_HOLD_UNTIL_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
        (state == SEQ_HOLD && rstBit) |=> coreRst) else $error("held reset removed early"); // R6
    end
  endgenerate

  AST_CLK_STOP: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(coreRst) |-> !coreClkEn) else $error("reset moved with clock running"); // R8
  AST_NO_EARLY_EXIT: assert property (@(posedge clk) disable iff (!rstN)
    (waiting && !cntZero) |=> state == $past(state)) else $error("phase ended before count"); // R7

endmodule

// File: rtl/cpu_rst_ctl.sv
module cpu_rst_ctl
  import cpu_rst_pkg::*;
#(
  parameter int DATA_W       = 32,
  parameter int CNT_W        = 4,
  parameter bit AUTO_RELEASE = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  input  logic              tick,
  input  logic [CNT_W-1:0]  cfgTicks,
  input  logic              flushDone,
  output logic              coreRst,
  output logic              coreClkEn,
  output logic              flushReq
);

  seqStrobe_t strb;
  logic rstBit;

  cpu_rst_regs #(.DATA_W(DATA_W)) u_regs (
    .clk       (clk),
    .rstN      (rstN),
    .wrEn      (wrEn),
    .wrData    (wrData),
    .flushDone (flushDone),
    .strb      (strb),
    .rstBit    (rstBit),
    .flushBit  (flushReq),
    .rdData    (rdData)
  );

  cpu_rst_seq #(.CNT_W(CNT_W), .AUTO_RELEASE(AUTO_RELEASE)) u_seq (
    .clk       (clk),
    .rstN      (rstN),
    .rstBit    (rstBit),
    .tick      (tick),
    .cfgTicks  (cfgTicks),
    .strb      (strb),
    .coreRst   (coreRst),
    .coreClkEn (coreClkEn)
  );

endmodule

// File: tb/sim_cpu_rst_ctl.sv
`timescale 1ns/1ps
module sim_cpu_rst_ctl;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrEn = 1'b0;
  logic [31:0] wrData = '0;
  logic tick = 1'b0;
  logic [3:0] cfgTicks = '0;
  logic flushDone = 1'b0;

  logic [31:0] rd0, rd1;
  logic rst0, rst1, ce0, ce1, fl0, fl1;

  always #2.5 clk = ~clk;

  cpu_rst_ctl #(.AUTO_RELEASE(1'b1)) u0 (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData), .rdData(rd0),
    .tick(tick), .cfgTicks(cfgTicks), .flushDone(flushDone),
    .coreRst(rst0), .coreClkEn(ce0), .flushReq(fl0));

  cpu_rst_ctl #(.AUTO_RELEASE(1'b0)) u1 (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData), .rdData(rd1),
    .tick(tick), .cfgTicks(cfgTicks), .flushDone(flushDone),
    .coreRst(rst1), .coreClkEn(ce1), .flushReq(fl1));

  typedef struct {
    logic        sel;
    logic        eRst;
    logic        eCe;
    logic        eFl;
    logic [31:0] eRd;
    string       tag;
  } exp_t;

  exp_t q[$];
  int checks = 0;
  int fails = 0;
  logic target = 1'b0;
  logic finished = 1'b0;

  // driver: set inputs for the next rising edge, queue what must follow it
  task automatic step(input logic w, input logic [31:0] d, input logic t,
                      input logic fd, input logic eRst, input logic eCe,
                      input logic eFl, input logic [31:0] eRd, input string tag);
    exp_t it;
    @(negedge clk);
    wrEn = w; wrData = d; tick = t; flushDone = fd;
    it.sel = target; it.eRst = eRst; it.eCe = eCe; it.eFl = eFl;
    it.eRd = eRd; it.tag = tag;
    q.push_back(it);
  endtask

  task automatic idle(input logic eRst, input logic eCe, input logic eFl,
                      input logic [31:0] eRd, input string tag);
    step(1'b0, 32'h0, 1'b0, 1'b0, eRst, eCe, eFl, eRd, tag);
  endtask

  task automatic tk(input logic eRst, input logic eCe, input logic eFl,
                    input logic [31:0] eRd, input string tag);
    step(1'b0, 32'h0, 1'b1, 1'b0, eRst, eCe, eFl, eRd, tag);
  endtask

  task automatic drain();
    @(negedge clk);
    wrEn = 1'b0; wrData = '0; tick = 1'b0; flushDone = 1'b0;
    while (q.size() != 0) @(negedge clk);
  endtask

  // monitor: compare one nanosecond after each rising edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (q.size() != 0) begin
        exp_t it;
        logic aRst, aCe, aFl;
        logic [31:0] aRd;
        it = q.pop_front();
        aRst = it.sel ? rst1 : rst0;
        aCe  = it.sel ? ce1  : ce0;
        aFl  = it.sel ? fl1  : fl0;
        aRd  = it.sel ? rd1  : rd0;
        checks++;
        if (aRst !== it.eRst || aCe !== it.eCe || aFl !== it.eFl || aRd !== it.eRd) begin
          fails++;
          $display("FAIL %s u%0d: rst=%0b clkEn=%0b flush=%0b rd=%h expected rst=%0b clkEn=%0b flush=%0b rd=%h",
                   it.tag, it.sel, aRst, aCe, aFl, aRd, it.eRst, it.eCe, it.eFl, it.eRd);
        end
      end
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      fails++;
      $display("FAIL watchdog: run did not end, expected completion");
      $display("[TB] %0d tests run, %0d failed", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // ---------------- self-releasing variant (u0) ----------------
    target = 1'b0;
    idle(0, 1, 0, 32'h0, "R1");
    cfgTicks = 4'd2;
    step(1, 32'h0001_0001, 0, 0, 0, 1, 0, 32'h1, "R4");  // bit set, sequencer not yet
    idle(1, 0, 0, 32'h1, "R8");                          // apply phase, clock stopped
    step(1, 32'h0001_0000, 0, 0, 1, 0, 0, 32'h1, "R5");  // cancel attempt ignored
    tk(1, 0, 0, 32'h1, "R7");
    tk(1, 0, 0, 32'h1, "R7");                            // count reaches zero
    idle(0, 0, 0, 32'h1, "R7");                          // removal phase starts
    tk(0, 0, 0, 32'h1, "R7");
    tk(0, 0, 0, 32'h1, "R7");
    idle(0, 1, 0, 32'h1000, "R4");                       // released, done set
    step(1, 32'h0000_0001, 0, 0, 0, 1, 0, 32'h1000, "R2");
    idle(0, 1, 0, 32'h1000, "R2");                       // no start without enable
    step(1, 32'h0000_1000, 0, 0, 0, 1, 0, 32'h1000, "R3");
    step(1, 32'h1000_0000, 0, 0, 0, 1, 0, 32'h1000, "R3");
    step(1, 32'h1000_1000, 0, 0, 0, 1, 0, 32'h0, "R3");

    cfgTicks = 4'd0;
    step(1, 32'h0001_0001, 0, 0, 0, 1, 0, 32'h1, "R7");
    idle(1, 0, 0, 32'h1, "R7");
    idle(0, 0, 0, 32'h1, "R7");
    step(1, 32'h1000_1000, 0, 0, 0, 1, 0, 32'h1000, "R3");  // set beats clear
    step(1, 32'h1000_1000, 0, 0, 0, 1, 0, 32'h0, "R3");

    step(1, 32'h0000_0010, 0, 0, 0, 1, 0, 32'h0, "R2");
    step(1, 32'h0010_0010, 0, 0, 0, 1, 1, 32'h10, "R9");
    idle(0, 1, 1, 32'h10, "R9");
    step(0, 32'h0, 0, 1, 0, 1, 0, 32'h0, "R9");
    step(0, 32'h0, 0, 1, 0, 1, 0, 32'h0, "R9");
    step(1, 32'hFFFE_FFFF, 0, 0, 0, 1, 1, 32'h10, "R10");
    step(0, 32'h0, 0, 1, 0, 1, 0, 32'h0, "R10");
    drain();

    // ---------------- held variant (u1) ----------------
    @(negedge clk);
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    target = 1'b1;
    idle(0, 1, 0, 32'h0, "R1");
    cfgTicks = 4'd1;
    step(1, 32'h0001_0001, 0, 0, 0, 1, 0, 32'h1, "R6");
    idle(1, 0, 0, 32'h1, "R6");
    tk(1, 0, 0, 32'h1, "R7");
    idle(1, 1, 0, 32'h1, "R6");                          // holding, clock back
    idle(1, 1, 0, 32'h1, "R6");
    tk(1, 1, 0, 32'h1, "R6");                            // no done while held
    step(1, 32'h0001_0000, 0, 0, 1, 1, 0, 32'h0, "R6");
    idle(0, 0, 0, 32'h0, "R8");                          // removal, clock stopped
    tk(0, 0, 0, 32'h0, "R7");
    idle(0, 1, 0, 32'h1000, "R6");
    drain();

    if (!finished) begin
      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", checks, fails);
      $finish;
    end
  end

endmodule